// File: doc/BRIEF.md
# Sampling Phase Eye Centre Calibrator

This block places the sampling clock of a source-synchronous receiver in the middle of its valid data window. It never touches clock hardware directly. It asks an external phase shifter to move one unit step at a time through a request/acknowledge pair, and it judges each position from a single pass/fail line driven by a data checker. The checker's line is only trusted after a programmable settle interval has passed since the last step.

In fine mode a calibration run has three parts. First the phase walks earlier until a failing position is reached. Then it walks later, past the failing region, to the first position that passes. It keeps walking later while positions pass, and stops at the first position that fails again. The block then walks back to the arithmetic centre of the passing span and reports the width of that span in steps. In coarse mode, meant for slow interfaces, the block evaluates eighth-of-a-period positions and stops at the first one that passes.

The chosen phase is held until software pulses start again. Because every move goes through the run-time step port, nothing needs to be rebuilt to retune. If no usable position turns up within one period's worth of stepping, the block raises an error flag in place of the done flag.

Top module: `eye_center_cal`

## Requirements
- R1: After reset, the phase position reads 0 and busy, done, error and step request are all low.
- R2: A step request is held high with a stable direction (1 = later, 0 = earlier) until acknowledged. Each cycle in which request and acknowledge are both high moves the signed position by exactly one step in that direction, and the position changes at no other time.
- R3: After the last step of a move, the pass/fail input is ignored for SETTLE cycles. It is then sampled for NSAMP cycles, and the position counts as passing only if every sample was high.
- R4: In fine mode the block first steps earlier, one step at a time, until a position fails.
- R5: In fine mode the block next steps later, one step at a time, to the first passing position, then keeps stepping later until the first failing position after it.
- R6: A successful fine run ends with the phase at first + floor((last - first) / 2), where first and last are the first and last passing positions. The width output then reads last - first + 1, and done is high.
- R7: In coarse mode the block first evaluates the current position. After each failure it moves PERIOD_STEPS/8 steps later. It stops with done high at the first passing position, and the width output reads 0.
- R8: The error flag is raised, done stays low, and the phase is held where it is in two cases. In fine mode, any sweep runs PERIOD_STEPS steps without reaching its goal. In coarse mode, none of eight positions passes.
- R9: Once a run ends, the phase position stays constant and no step is requested until the next start.
- R10: A start pulse that arrives while a run is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse to begin a calibration run |
| coarse_i | input | 1 | Selects coarse mode, captured together with start |
| sample_ok_i | input | 1 | Pass/fail indication from the data checker |
| step_ack_i | input | 1 | Phase shifter has applied one step |
| step_req_o | output | 1 | Request for one phase step |
| step_later_o | output | 1 | Step direction: 1 later, 0 earlier |
| phase_pos_o | output | POS_W | Signed phase position in unit steps |
| busy_o | output | 1 | Calibration run in progress |
| cal_done_o | output | 1 | Last run ended on a centred phase |
| cal_error_o | output | 1 | Last run found no usable window |
| win_width_o | output | WID_W | Passing window width in steps (fine mode) |

## Verification
A wrong sweep phase or a miscounted limit shows up at the ports as a final position that differs from the predicted centre. The bench reads that position as soon as busy falls, one run at a time. A settle or sample counter that is off by one makes the block accept a position while the checker line is still noisy, or accept a position whose samples toggle. That corrupts the first or last passing edge, and so the reported width, within the same run. The bench tracks the phase on its own from the acknowledges. A position counter that drifts from the step handshake is therefore caught at the end of the run in which it slips, and the bound assertions in the stepping logic flag it on the very next cycle.

// File: rtl/eye_cal_pkg.sv
package eye_cal_pkg;

  typedef enum logic [2:0] {
    PH_EARLY,
    PH_SEEK,
    PH_TRACK,
    PH_RETURN,
    PH_COARSE
  } sweep_ph_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_MOVE,
    ST_EVAL
  } cal_st_e;

  // Centre of a passing span, rounded toward the first position.
  function automatic int span_centre(input int first_pos, input int last_pos);
    return first_pos + ((last_pos - first_pos) >>> 1);
  endfunction

  // Number of passing positions, both ends included.
  function automatic int span_width(input int first_pos, input int last_pos);
    return last_pos - first_pos + 1;
  endfunction

endpackage

// File: rtl/eye_cal_stepper.sv
module eye_cal_stepper #(
  parameter int POS_W = 9
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    go_i,
  input  logic                    later_i,
  input  logic [POS_W-1:0]        count_i,
  input  logic                    ack_i,
  output logic                    req_o,
  output logic                    later_o,
  output logic signed [POS_W-1:0] pos_o,
  output logic                    done_o
);

  localparam logic signed [POS_W-1:0] ONE = 1;

  logic             active;
  logic             dir_q;
  logic [POS_W-1:0] remain;
  logic             take_step;

  assign take_step = active && ack_i;
  assign req_o     = active;
  assign later_o   = dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      dir_q  <= 1'b0;
      remain <= '0;
      pos_o  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i && !active) begin
        active <= (count_i != '0);
        remain <= count_i;
        dir_q  <= later_i;
        done_o <= (count_i == '0);
      end else if (take_step) begin
        pos_o  <= dir_q ? pos_o + ONE : pos_o - ONE;
        remain <= remain - 1'b1;
        if (remain == POS_W'(1)) begin
          active <= 1'b0;
          done_o <= 1'b1;
        end
      end
    end
  end

  // R2: the position moves only by one unit and only after an accepted step
  assert_pos_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_o != $past(pos_o)) |->
      ($past(req_o && ack_i) &&
       ((pos_o - $past(pos_o) == ONE) || ($past(pos_o) - pos_o == ONE))));

  // R2: an unanswered request stays up with the same direction
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_o && !ack_i) |=> (req_o && $stable(later_o)));

endmodule

// File: rtl/eye_cal_judge.sv
module eye_cal_judge #(
  parameter int SETTLE = 4,
  parameter int NSAMP  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic ok_i,
  output logic done_o,
  output logic pass_o
);

  localparam int LONGEST = (SETTLE > NSAMP) ? SETTLE : NSAMP;
  localparam int CW      = $clog2(LONGEST + 1) + 1;

  typedef enum logic [1:0] { J_IDLE, J_SETTLE, J_SAMPLE } judge_st_e;

  judge_st_e       st;
  logic [CW-1:0]   cnt;
  logic            all_ok;
  logic            in_sample;

  assign in_sample = (st == J_SAMPLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= J_IDLE;
      cnt    <= '0;
      all_ok <= 1'b0;
      done_o <= 1'b0;
      pass_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (st)
        J_IDLE: if (go_i) begin
          st     <= J_SETTLE;
          cnt    <= CW'(SETTLE - 1);
          all_ok <= 1'b1;
        end
        J_SETTLE: begin
          if (cnt == '0) begin
            st  <= J_SAMPLE;
            cnt <= CW'(NSAMP - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        J_SAMPLE: begin
          all_ok <= all_ok && ok_i;
          if (cnt == '0) begin
            st     <= J_IDLE;
            done_o <= 1'b1;
            pass_o <= all_ok && ok_i;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: st <= J_IDLE;
      endcase
    end
  end

  // R3: a verdict follows only from the sampling window
  assert_verdict_after_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(in_sample));

  // R3: a passing verdict needs the final sample high
  assert_pass_needs_ok_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && pass_o) |-> $past(ok_i));

endmodule

// File: rtl/eye_center_cal.sv
module eye_center_cal
  import eye_cal_pkg::*;
#(
  parameter int PERIOD_STEPS = 64,
  parameter int SETTLE       = 4,
  parameter int NSAMP        = 4,
  parameter int POS_W        = $clog2(PERIOD_STEPS) + 3,
  parameter int WID_W        = $clog2(PERIOD_STEPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start_i,
  input  logic                    coarse_i,
  input  logic                    sample_ok_i,
  input  logic                    step_ack_i,
  output logic                    step_req_o,
  output logic                    step_later_o,
  output logic signed [POS_W-1:0] phase_pos_o,
  output logic                    busy_o,
  output logic                    cal_done_o,
  output logic                    cal_error_o,
  output logic [WID_W-1:0]        win_width_o
);

  localparam int CNT_W        = $clog2(PERIOD_STEPS + 1) + 1;
  localparam int COARSE_STEPS = PERIOD_STEPS / 8;
  localparam int COARSE_POSNS = 8;

  cal_st_e                 st;
  sweep_ph_e               ph;
  logic [CNT_W-1:0]        sweep_cnt;
  logic signed [POS_W-1:0] first_q, last_q, centre_d;
  logic                    move_go, move_later, move_done;
  logic [POS_W-1:0]        move_cnt;
  logic                    eval_go, eval_done, eval_pass;
  logic                    coarse_q;
  logic                    sweep_limit;

  assign sweep_limit = (sweep_cnt == CNT_W'(PERIOD_STEPS));
  assign centre_d    = POS_W'(span_centre(int'(first_q), int'(last_q)));

  eye_cal_stepper #(.POS_W(POS_W)) u_stepper (
    .clk     (clk),
    .rst_n   (rst_n),
    .go_i    (move_go),
    .later_i (move_later),
    .count_i (move_cnt),
    .ack_i   (step_ack_i),
    .req_o   (step_req_o),
    .later_o (step_later_o),
    .pos_o   (phase_pos_o),
    .done_o  (move_done)
  );

  eye_cal_judge #(.SETTLE(SETTLE), .NSAMP(NSAMP)) u_judge (
    .clk    (clk),
    .rst_n  (rst_n),
    .go_i   (eval_go),
    .ok_i   (sample_ok_i),
    .done_o (eval_done),
    .pass_o (eval_pass)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      ph          <= PH_EARLY;
      sweep_cnt   <= '0;
      first_q     <= '0;
      last_q      <= '0;
      move_go     <= 1'b0;
      move_later  <= 1'b0;
      move_cnt    <= '0;
      eval_go     <= 1'b0;
      coarse_q    <= 1'b0;
      busy_o      <= 1'b0;
      cal_done_o  <= 1'b0;
      cal_error_o <= 1'b0;
      win_width_o <= '0;
    end else begin
      move_go <= 1'b0;
      eval_go <= 1'b0;
      unique case (st)
        ST_IDLE: if (start_i) begin
          busy_o      <= 1'b1;
          cal_done_o  <= 1'b0;
          cal_error_o <= 1'b0;
          win_width_o <= '0;
          coarse_q    <= coarse_i;
          sweep_cnt   <= (coarse_i) ? CNT_W'(0) : CNT_W'(1);
          if (coarse_i) begin
            ph      <= PH_COARSE;
            eval_go <= 1'b1;
            st      <= ST_EVAL;
          end else begin
            ph         <= PH_EARLY;
            move_go    <= 1'b1;
            move_later <= 1'b0;
            move_cnt   <= POS_W'(1);
            st         <= ST_MOVE;
          end
        end
        ST_MOVE: if (move_done) begin
          if (ph == PH_RETURN) begin
            busy_o     <= 1'b0;
            cal_done_o <= 1'b1;
            st         <= ST_IDLE;
          end else begin
            eval_go <= 1'b1;
            st      <= ST_EVAL;
          end
        end
        ST_EVAL: if (eval_done) begin
          st       <= ST_MOVE;
          move_go  <= 1'b1;
          move_cnt <= POS_W'(1);
          unique case (ph)
            PH_EARLY: begin
              if (!eval_pass) begin
                ph         <= PH_SEEK;
                sweep_cnt  <= CNT_W'(1);
                move_later <= 1'b1;
              end else begin
                sweep_cnt  <= sweep_cnt + 1'b1;
                move_later <= 1'b0;
              end
              if (eval_pass && sweep_limit) begin
                move_go <= 1'b0;
                st      <= ST_IDLE;
                busy_o  <= 1'b0;
                cal_error_o <= 1'b1;
              end
            end
            PH_SEEK: begin
              move_later <= 1'b1;
              if (eval_pass) begin
                ph        <= PH_TRACK;
                first_q   <= phase_pos_o;
                last_q    <= phase_pos_o;
                sweep_cnt <= CNT_W'(1);
              end else if (sweep_limit) begin
                move_go     <= 1'b0;
                st          <= ST_IDLE;
                busy_o      <= 1'b0;
                cal_error_o <= 1'b1;
              end else begin
                sweep_cnt <= sweep_cnt + 1'b1;
              end
            end
            PH_TRACK: begin
              if (!eval_pass) begin
                ph          <= PH_RETURN;
                move_later  <= 1'b0;
                move_cnt    <= POS_W'(phase_pos_o - centre_d);
                win_width_o <= WID_W'(span_width(int'(first_q), int'(last_q)));
              end else if (sweep_limit) begin
                move_go     <= 1'b0;
                st          <= ST_IDLE;
                busy_o      <= 1'b0;
                cal_error_o <= 1'b1;
              end else begin
                last_q     <= phase_pos_o;
                sweep_cnt  <= sweep_cnt + 1'b1;
                move_later <= 1'b1;
              end
            end
            PH_COARSE: begin
              move_later <= 1'b1;
              move_cnt   <= POS_W'(COARSE_STEPS);
              if (eval_pass) begin
                move_go    <= 1'b0;
                st         <= ST_IDLE;
                busy_o     <= 1'b0;
                cal_done_o <= 1'b1;
              end else if (sweep_cnt == CNT_W'(COARSE_POSNS - 1)) begin
                move_go     <= 1'b0;
                st          <= ST_IDLE;
                busy_o      <= 1'b0;
                cal_error_o <= 1'b1;
              end else begin
                sweep_cnt <= sweep_cnt + 1'b1;
              end
            end
            default: begin
              move_go <= 1'b0;
              st      <= ST_IDLE;
              busy_o  <= 1'b0;
            end
          endcase
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9: steps are only requested during a run
  assert_req_in_run_R9: assert property (@(posedge clk) disable iff (!rst_n)
    step_req_o |-> busy_o);

  // R9: the phase is held between runs
  assert_hold_between_runs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && $past(!busy_o)) |-> $stable(phase_pos_o));

  // R8: a run never ends both centred and failed
  assert_done_error_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_done_o && cal_error_o));

  // R6: a centred fine run reports a non-empty window
  assert_fine_width_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cal_done_o) && !coarse_q) |-> (win_width_o != '0));

  // R10: a run in progress stays in progress when start is pulsed again
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !move_done && !eval_done) |=> busy_o);

endmodule

// File: tb/test_eye_center_cal.sv
module test_eye_center_cal;

  localparam int CLK_PERIOD = 10;
  localparam int P      = 64;
  localparam int SET    = 4;
  localparam int NS     = 4;
  localparam int POS_W  = $clog2(P) + 3;
  localparam int WID_W  = $clog2(P + 1);
  localparam int CSTEP  = P / 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic coarse_i = 1'b0;
  logic sample_ok_i;
  logic step_ack_i = 1'b0;
  logic step_req_o, step_later_o, busy_o, cal_done_o, cal_error_o;
  logic signed [POS_W-1:0] phase_pos_o;
  logic [WID_W-1:0] win_width_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  eye_center_cal #(.PERIOD_STEPS(P), .SETTLE(SET), .NSAMP(NS)) i_eye_center_cal (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .coarse_i(coarse_i),
    .sample_ok_i(sample_ok_i), .step_ack_i(step_ack_i),
    .step_req_o(step_req_o), .step_later_o(step_later_o),
    .phase_pos_o(phase_pos_o), .busy_o(busy_o), .cal_done_o(cal_done_o),
    .cal_error_o(cal_error_o), .win_width_o(win_width_o)
  );

  // Phase shifter and checker model
  int bpos = 0;
  int eye_lo = 0;
  int eye_hi = -1;
  int flake_pos = 10000;
  int settle_left = 0;
  bit toggle = 1'b0;

  assign sample_ok_i = (bpos >= eye_lo) && (bpos <= eye_hi) && (settle_left == 0)
                       && !((bpos == flake_pos) && toggle);

  always @(negedge clk) begin
    toggle = ~toggle;
    if (rst_n) begin
      if (step_ack_i) begin
        step_ack_i = 1'b0;
      end else if (step_req_o) begin
        step_ack_i = 1'b1;
        bpos = step_later_o ? bpos + 1 : bpos - 1;
        settle_left = SET - 1;
      end else if (settle_left > 0) begin
        settle_left = settle_left - 1;
      end
    end
  end

  int checks = 0;
  int bad = 0;

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit good_at(input int p);
    return (p >= eye_lo) && (p <= eye_hi) && (p != flake_pos);
  endfunction

  typedef struct {
    string tag;
    int    pos;
    int    width;
    bit    done;
    bit    err;
  } exp_t;

  exp_t sb[$];

  // Expected outcome, worked out as a walk over the bench's own eye
  function automatic exp_t predict(input int s, input bit coarse, input string tag);
    exp_t e;
    int p, n, first_p, last_p;
    e.tag = tag; e.width = 0; e.done = 1'b0; e.err = 1'b1;
    if (coarse) begin
      for (int k = 0; k < 8; k++) begin
        e.pos = s + k * CSTEP;
        if (good_at(e.pos)) begin
          e.done = 1'b1; e.err = 1'b0;
          return e;
        end
      end
      return e;
    end
    p = s - 1; n = 1;
    while (good_at(p)) begin
      if (n == P) begin e.pos = p; return e; end
      p--; n++;
    end
    p++; n = 1;
    while (!good_at(p)) begin
      if (n == P) begin e.pos = p; return e; end
      p++; n++;
    end
    first_p = p;
    p++; n = 1;
    while (good_at(p)) begin
      if (n == P) begin e.pos = p; return e; end
      p++; n++;
    end
    last_p = p - 1;
    e.width = last_p - first_p + 1;
    e.pos = first_p + (last_p - first_p) / 2;
    e.done = 1'b1; e.err = 1'b0;
    return e;
  endfunction

  // Monitor: compares each finished run against the scoreboard
  bit busy_prev = 1'b0;
  always @(negedge clk) begin
    if (busy_prev && !busy_o) begin
      exp_t e;
      if (sb.size() == 0) begin
        checks++; bad++;
        $display("FAIL R10 unexpected run end actual=1 expected=0");
      end else begin
        e = sb.pop_front();
        check_eq(e.tag, "final phase", int'(phase_pos_o), e.pos);
        check_eq("R2", "phase vs acknowledged steps", int'(phase_pos_o), bpos);
        check_eq(e.tag, "done flag", int'(cal_done_o), int'(e.done));
        check_eq(e.tag, "error flag", int'(cal_error_o), int'(e.err));
        check_eq(e.tag, "window width", int'(win_width_o), e.width);
      end
    end
    busy_prev = busy_o;
  end

  // Driver
  task automatic run_cal(input int lo, input int hi, input int flake, input bit coarse,
                         input string tag, input bit poke);
    int held, reqs;
    eye_lo = lo; eye_hi = hi; flake_pos = flake;
    sb.push_back(predict(bpos, coarse, tag));
    @(negedge clk); start_i = 1'b1; coarse_i = coarse;
    @(negedge clk); start_i = 1'b0;
    if (poke) begin
      // R10: a second start mid-run, with the other mode, must change nothing
      repeat (40) @(negedge clk);
      start_i = 1'b1; coarse_i = ~coarse;
      @(negedge clk); start_i = 1'b0;
    end
    while (busy_o) @(negedge clk);
    // R9: phase held and no requests after the run
    held = int'(phase_pos_o); reqs = 0;
    repeat (30) begin
      @(negedge clk);
      if (step_req_o) reqs++;
    end
    check_eq("R9", "phase held after run", int'(phase_pos_o), held);
    check_eq("R9", "requests after run", reqs, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check_eq("R1", "phase at reset", int'(phase_pos_o), 0);
    check_eq("R1", "busy at reset", int'(busy_o), 0);
    check_eq("R1", "done at reset", int'(cal_done_o), 0);
    check_eq("R1", "error at reset", int'(cal_error_o), 0);
    check_eq("R1", "request at reset", int'(step_req_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R4 R5 R6: start inside a symmetric window, with a mid-run start poke (R10)
    run_cal(-5, 6, 10000, 1'b0, "R6", 1'b1);
    check_eq("R6", "centred phase", int'(phase_pos_o), 0);
    check_eq("R6", "width", int'(win_width_o), 12);
    // R5: window lies later than the start; R3: a toggling edge position must fail
    run_cal(3, 10, 10, 1'b0, "R3", 1'b0);
    check_eq("R3", "toggling position excluded", int'(win_width_o), 7);
    // R4: single-step window at the start position
    run_cal(6, 6, 10000, 1'b0, "R4", 1'b0);
    check_eq("R4", "one-step window", int'(win_width_o), 1);
    // R7: coarse mode stops at the first passing eighth
    run_cal(20, 30, 10000, 1'b1, "R7", 1'b0);
    check_eq("R7", "coarse phase", int'(phase_pos_o), 22);
    // R8: coarse mode with no passing position
    run_cal(200, 210, 10000, 1'b1, "R8", 1'b0);
    check_eq("R8", "coarse error held phase", int'(phase_pos_o), 22 + 7 * CSTEP);
    // R8: fine mode with no passing position
    run_cal(1, 0, 10000, 1'b0, "R8", 1'b0);
    // R6: recovery after an error, window starting earlier than the phase
    run_cal(138, 150, 10000, 1'b0, "R6", 1'b0);
    check_eq("R6", "recovered centre", int'(phase_pos_o), 144);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog run did not finish actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule